// File: doc/BRIEF.md
# Precision Time Counter with Auxiliary Snapshots

This block keeps a 64-bit time count in units of 32 ns. A 32-bit rate word is added to a 32-bit phase accumulator on every reference clock. Each carry out of that accumulator advances the time by one unit. With a 50 MHz reference, the nominal rate word 0xA0000000 (0.625 of full scale) gives exactly one 32 ns unit per 20 ns clock on average. Software trims the frequency by rewriting the rate word. It can read, write and step the time as two 32-bit halves.

Two auxiliary strobe inputs are synchronized and edge-detected. Each rising edge copies the running time into that channel's 64-bit snapshot and raises a sticky flag. A 64-bit target register raises its own flag once the time reaches it. All flags sit in one event word and are cleared by writing ones to them. A control bit holds the timing logic in a soft reset.

Access goes through a single-cycle request bus: one request per cycle, word addressed. Read data appears on `reg_rdata` one clock after the read request and holds until the next read.

Top module: `ptp_time_core`

Register map (word address: content):
- 0: control; bit 0 is the soft reset.
- 1: events.
- 2: rate word.
- 3: time low.
- 4: time high.
- 5: target low.
- 6: target high.
- 7 and 8: auxiliary channel 0 snapshot, low then high.
- 9 and 10: auxiliary channel 1 snapshot, low then high.

## Requirements
- R1: After the reset input is released, the rate word reads 0xA0000000, the time is 0, the event word reads 0, the target reads 0xFFFFFFFF in both halves, and the control word reads 0.
- R2: On every clock the time increases by exactly the carry out of the 32-bit sum accumulator + rate word, and the accumulator keeps the low 32 bits of that sum. With the nominal rate word, the time gains exactly 5 counts in any 8 consecutive clocks, and a carry out of the low word propagates into the high word.
- R3: A newly written rate word is used from the next clock. A rate word of 0 freezes the time. A rate word of 0x80000000 gives 4 counts per 8 clocks. A rate word of 0xFFFFFFFF gives 7 or 8 counts per 8 clocks.
- R4: Reading time low (address 3) returns the low half and stores the high half of that same time in a shadow. A read of time high (address 4) returns the shadow, even if the live high half has changed since.
- R5: A write to time low only stores a pending value, and the time keeps counting. The next write to time high loads the whole time as {written high, pending low}, and the count continues from that value.
- R6: While control bit 0 is 1, the time, the accumulator, all event flags and all snapshots are held at 0. Once the bit is written back to 0, the time counts up from 0 again.
- R7: A rising edge on aux_in[c] passes through two synchronizing flops and an edge detector. The third clock edge after the input rises copies the time into snapshot c and sets event bit 2+c (bit 2 for channel 0, bit 3 for channel 1).
- R8: While event bit 2+c is set, further edges on aux_in[c] leave snapshot c unchanged. Once the flag is cleared, the next edge captures again.
- R9: Writing the event word clears exactly the flag bits written as 1 and leaves the others unchanged. A flag being set in the same cycle wins over the clear. Bits 0 and 4 and all bits from 5 upward always read 0.
- R10: The target match is time ≥ target. It sets event bit 1 once and then stays disarmed. It is armed again by clearing bit 1 or by writing either target half. After re-arming, a time already at or past the target fires again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| reg_req | input | 1 | Bus request, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after a read |
| aux_in | input | N_AUX (2) | Asynchronous auxiliary capture strobes |

## Verification
Most internal state can only be seen through a read. A wrong accumulator or rate word shows within eight clocks as a time-low delta that differs from the expected count. A wrong shadow shows on the very next time-high read. A broken pending-low path shows as a time value that steps at the wrong write. A wrong sync depth shifts the captured snapshot by one count or more, and this shows on the first snapshot read after the strobe. A target comparator that re-fires or never re-arms shows as a wrong bit 1 in the event word on the first event read after the match or the clear. The bench's model predicts `reg_rdata` on every clock, so any divergence is reported at the first read that exposes it.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned WORD_W = 32;

  localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] A_EVENT  = 4'd1;
  localparam logic [REG_AW-1:0] A_RATE   = 4'd2;
  localparam logic [REG_AW-1:0] A_TLO    = 4'd3;
  localparam logic [REG_AW-1:0] A_THI    = 4'd4;
  localparam logic [REG_AW-1:0] A_TGLO   = 4'd5;
  localparam logic [REG_AW-1:0] A_TGHI   = 4'd6;
  localparam int unsigned       A_SNAP0  = 7;

  localparam logic [WORD_W-1:0] RATE_NOMINAL = 32'hA000_0000;
  localparam int unsigned EV_TARGET_BIT = 1;
  localparam int unsigned EV_AUX_BASE   = 2;

  // Phase accumulator step: {carry, new accumulator}
  function automatic logic [WORD_W:0] phase_step(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] rate);
    return {1'b0, acc} + {1'b0, rate};
  endfunction
endpackage

// File: rtl/ptpc_rate.sv
module ptpc_rate #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned TW = 2 * HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [31:0]   rate,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] time_o,
  output logic          tick_o
);
  import ptpc_pkg::*;

  logic [31:0] acc_q;
  logic [32:0] step;

  assign step   = phase_step(acc_q, rate);
  assign tick_o = step[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      time_o <= '0;
    end else if (soft_rst) begin
      acc_q  <= '0;
      time_o <= '0;
    end else begin
      acc_q <= step[31:0];
      if (load) time_o <= load_val;
      else      time_o <= time_o + TW'(tick_o);
    end
  end

  p_step_le_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !load) |=> ((time_o - $past(time_o)) <= TW'(1)));
  p_soft_holds_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (time_o == '0));
  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_rst) |=> (time_o == $past(load_val)));
endmodule

// File: rtl/ptpc_capture.sv
module ptpc_capture #(
  parameter int unsigned TW = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          strobe,
  input  logic [TW-1:0] time_i,
  input  logic          clr,
  output logic          flag_o,
  output logic [TW-1:0] snap_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic rise;

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      snap_o <= '0;
    end else if (soft_rst) begin
      flag_o <= 1'b0;
      snap_o <= '0;
    end else if (rise && !flag_o) begin
      flag_o <= 1'b1;
      snap_o <= time_i;
    end else if (clr) begin
      flag_o <= 1'b0;
    end
  end

  p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !soft_rst && !flag_o) |=> (flag_o && snap_o == $past(time_i)));
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !soft_rst) |=> $stable(snap_o));
endmodule

// File: rtl/ptpc_target.sv
module ptpc_target #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] target_i,
  input  logic          rearm,
  input  logic          clr,
  output logic          flag_o,
  output logic          fire_o
);
  logic armed_q;

  assign fire_o = armed_q && (time_i >= target_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      flag_o  <= 1'b0;
    end else if (soft_rst) begin
      armed_q <= 1'b1;
      flag_o  <= 1'b0;
    end else begin
      if (rearm || clr) armed_q <= 1'b1;
      else if (fire_o)  armed_q <= 1'b0;
      flag_o <= fire_o | (flag_o & ~clr);
    end
  end

  p_fires_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !rearm && !clr && !soft_rst) |=> !fire_o);
  p_fire_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !soft_rst) |=> flag_o);
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
  parameter int unsigned N_AUX = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HALF_W = 32,
  localparam int unsigned TW = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_AUX-1:0]  aux_in
);
  import ptpc_pkg::*;

  logic wr, rd;
  logic ctrl_q;
  logic [31:0] rate_q, pend_lo_q, shadow_q;
  logic [TW-1:0] target_q, time_w;
  logic tick_w;
  logic ev_wr, tgt_wr, load_w;
  logic tgt_flag, tgt_fire;
  logic [N_AUX-1:0] aux_flag;
  logic [TW-1:0] snap_w [N_AUX];
  logic [31:0] ev_word, rd_mux;

  assign wr     = reg_req &  reg_we;
  assign rd     = reg_req & ~reg_we;
  assign ev_wr  = wr && (reg_addr == A_EVENT);
  assign tgt_wr = wr && ((reg_addr == A_TGLO) || (reg_addr == A_TGHI));
  assign load_w = wr && (reg_addr == A_THI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 1'b0;
      rate_q    <= RATE_NOMINAL;
      pend_lo_q <= '0;
      target_q  <= '1;
    end else if (wr) begin
      case (reg_addr)
        A_CTRL: ctrl_q    <= reg_wdata[0];
        A_RATE: rate_q    <= reg_wdata;
        A_TLO:  pend_lo_q <= reg_wdata;
        A_TGLO: target_q[HALF_W-1:0]  <= reg_wdata;
        A_TGHI: target_q[TW-1:HALF_W] <= reg_wdata;
        default: ;
      endcase
    end
  end

  ptpc_rate #(.HALF_W(HALF_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .rate(rate_q),
    .load(load_w), .load_val({reg_wdata, pend_lo_q}),
    .time_o(time_w), .tick_o(tick_w)
  );

  ptpc_target #(.TW(TW)) u_target (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .time_i(time_w),
    .target_i(target_q), .rearm(tgt_wr),
    .clr(ev_wr && reg_wdata[EV_TARGET_BIT]),
    .flag_o(tgt_flag), .fire_o(tgt_fire)
  );

  for (genvar c = 0; c < N_AUX; c++) begin : g_aux
    ptpc_capture #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .soft_rst(ctrl_q), .strobe(aux_in[c]),
      .time_i(time_w), .clr(ev_wr && reg_wdata[EV_AUX_BASE + c]),
      .flag_o(aux_flag[c]), .snap_o(snap_w[c])
    );
  end

  always_comb begin
    ev_word = '0;
    ev_word[EV_TARGET_BIT] = tgt_flag;
    for (int c = 0; c < N_AUX; c++) ev_word[EV_AUX_BASE + c] = aux_flag[c];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:  rd_mux = {31'b0, ctrl_q};
      A_EVENT: rd_mux = ev_word;
      A_RATE:  rd_mux = rate_q;
      A_TLO:   rd_mux = time_w[HALF_W-1:0];
      A_THI:   rd_mux = shadow_q;
      A_TGLO:  rd_mux = target_q[HALF_W-1:0];
      A_TGHI:  rd_mux = target_q[TW-1:HALF_W];
      default: ;
    endcase
    for (int c = 0; c < N_AUX; c++) begin
      if (reg_addr == 4'(A_SNAP0 + 2 * c))     rd_mux = snap_w[c][HALF_W-1:0];
      if (reg_addr == 4'(A_SNAP0 + 2 * c + 1)) rd_mux = snap_w[c][TW-1:HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      shadow_q  <= '0;
    end else if (rd) begin
      reg_rdata <= rd_mux;
      if (reg_addr == A_TLO) shadow_q <= time_w[TW-1:HALF_W];
    end
  end

  p_shadow_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_addr == A_TLO) |=> (shadow_q == $past(time_w[TW-1:HALF_W])));
  p_unused_ev_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word[0] == 1'b0) && (ev_word[31:EV_AUX_BASE + N_AUX] == '0));
  p_tick_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !ctrl_q && !load_w) |=> (time_w != $past(time_w)));
endmodule

// File: tb/ptp_time_core_tb_top.sv
module ptp_time_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] aux = '0;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  always #5 clk = ~clk;

  ptp_time_core dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req(req), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .aux_in(aux)
  );

  // ---------------- behavioural reference model ----------------
  longint unsigned m_time, m_acc, m_rate, m_pend, m_shadow, m_tgt;
  longint unsigned m_snap [2];
  bit m_ctrl, m_armed, m_ftgt;
  bit m_faux [2];
  bit [2:0] m_hist [2];
  logic [31:0] m_rdata;

  always @(posedge clk) begin : model
    longint unsigned sum, n_time;
    bit rdq, wrq, fire, clr_t;
    bit nf [2];
    if (!rst_n) begin
      m_time = 0; m_acc = 0; m_rate = 64'hA000_0000; m_pend = 0; m_shadow = 0;
      m_tgt = 64'hFFFF_FFFF_FFFF_FFFF; m_ctrl = 0; m_armed = 1; m_ftgt = 0;
      m_rdata = 0;
      for (int c = 0; c < 2; c++) begin m_snap[c] = 0; m_faux[c] = 0; m_hist[c] = 0; end
    end else begin
      rdq = req && !we;
      wrq = req && we;
      if (rdq) begin
        case (addr)
          0: m_rdata = {31'b0, m_ctrl};
          1: m_rdata = {28'b0, m_faux[1], m_faux[0], m_ftgt, 1'b0};
          2: m_rdata = m_rate[31:0];
          3: m_rdata = m_time[31:0];
          4: m_rdata = m_shadow[31:0];
          5: m_rdata = m_tgt[31:0];
          6: m_rdata = m_tgt[63:32];
          7: m_rdata = m_snap[0][31:0];
          8: m_rdata = m_snap[0][63:32];
          9: m_rdata = m_snap[1][31:0];
          10: m_rdata = m_snap[1][63:32];
          default: m_rdata = 0;
        endcase
        if (addr == 3) m_shadow = m_time >> 32;
      end
      // auxiliary channels: edge seen two samples after the input rose
      for (int c = 0; c < 2; c++) begin
        nf[c] = m_faux[c];
        if (m_hist[c][1] && !m_hist[c][2] && !m_faux[c]) begin
          nf[c] = 1; m_snap[c] = m_time;
        end else if (wrq && addr == 1 && wdata[2+c]) nf[c] = 0;
        m_hist[c] = {m_hist[c][1:0], aux[c]};
      end
      // target
      fire = m_armed && (m_time >= m_tgt);
      clr_t = wrq && addr == 1 && wdata[1];
      m_ftgt = fire || (m_ftgt && !clr_t);
      if (clr_t || (wrq && (addr == 5 || addr == 6))) m_armed = 1;
      else if (fire) m_armed = 0;
      for (int c = 0; c < 2; c++) m_faux[c] = nf[c];
      // time
      sum = m_acc + m_rate;
      n_time = m_time + (sum >> 32);
      if (wrq && addr == 4) n_time = {wdata, m_pend[31:0]};
      m_acc = sum & 64'hFFFF_FFFF;
      m_time = n_time;
      if (m_ctrl) begin
        m_time = 0; m_acc = 0; m_ftgt = 0; m_armed = 1;
        for (int c = 0; c < 2; c++) begin m_faux[c] = 0; m_snap[c] = 0; end
      end
      // register writes
      if (wrq) begin
        case (addr)
          0: m_ctrl = wdata[0];
          2: m_rate = wdata;
          3: m_pend = wdata;
          5: m_tgt = {m_tgt[63:32], wdata};
          6: m_tgt = {wdata, m_tgt[31:0]};
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string r, input bit ok, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", r, act, exp, $time);
    end
  endtask

  // per-clock comparison of the read port with the model
  always @(negedge clk) begin
    if (started && rst_n) check(cur_req, rdata === m_rdata, rdata, m_rdata);
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rate_window(input string r, input logic [31:0] rate,
                             input int lo_lim, input int hi_lim);
    logic [31:0] v0, v1, junk;
    bus_wr(4'd2, rate);
    idle(2);
    bus_rd(4'd3, v0);
    for (int k = 0; k < 3; k++) bus_rd(4'd2, junk);
    bus_rd(4'd3, v1);
    check(r, (v1 - v0) >= lo_lim && (v1 - v0) <= hi_lim, v1 - v0, lo_lim);
  endtask

  task automatic pulse(input int c);
    @(negedge clk); aux[c] = 1'b1;
    idle(3);
    aux[c] = 1'b0;
    idle(4);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    logic [31:0] v, lo, hi, s0;
    idle(3);
    rst_n = 1'b1;
    started = 1'b1;

    cur_req = "R1";
    bus_rd(4'd2, v); check("R1", v == 32'hA000_0000, v, 32'hA000_0000);
    bus_rd(4'd1, v); check("R1", v == 0, v, 0);
    bus_rd(4'd6, v); check("R1", v == 32'hFFFF_FFFF, v, 32'hFFFF_FFFF);
    bus_rd(4'd5, v); check("R1", v == 32'hFFFF_FFFF, v, 32'hFFFF_FFFF);
    bus_rd(4'd0, v); check("R1", v == 0, v, 0);
    bus_rd(4'd3, v); check("R1", v < 16, v, 0);

    cur_req = "R2";
    rate_window("R2", 32'hA000_0000, 5, 5);
    cur_req = "R3";
    rate_window("R3", 32'h0, 0, 0);
    rate_window("R3", 32'h8000_0000, 4, 4);
    rate_window("R3", 32'hFFFF_FFFF, 7, 8);
    bus_wr(4'd2, 32'hA000_0000);

    cur_req = "R5";
    bus_wr(4'd3, 32'h1234_5678);
    bus_rd(4'd3, v); check("R5", v < 32'h100, v, 0);
    bus_wr(4'd4, 32'h0000_0001);
    bus_rd(4'd3, lo); check("R5", lo >= 32'h1234_5678 && lo < 32'h1234_5680, lo, 32'h1234_5678);
    bus_rd(4'd4, hi); check("R5", hi == 1, hi, 1);

    cur_req = "R4";
    bus_wr(4'd3, 32'hFFFF_FFFE);
    bus_wr(4'd4, 32'h0000_0007);
    bus_rd(4'd3, lo);
    idle(20);
    bus_rd(4'd4, hi);
    check("R4", hi == ((lo >= 32'hFFFF_FFFE) ? 32'd7 : 32'd8), hi, 7);
    cur_req = "R2";
    bus_rd(4'd3, lo);
    bus_rd(4'd4, hi); check("R2", hi == 8, hi, 8);

    cur_req = "R6";
    bus_wr(4'd0, 32'h1);
    idle(3);
    bus_rd(4'd3, v); check("R6", v == 0, v, 0);
    bus_rd(4'd4, v); check("R6", v == 0, v, 0);
    bus_wr(4'd0, 32'h0);
    idle(10);
    bus_rd(4'd3, v); check("R6", v > 0 && v < 16, v, 6);

    cur_req = "R7";
    pulse(0);
    bus_rd(4'd1, v); check("R7", v == 32'h4, v, 32'h4);
    bus_rd(4'd7, s0);
    bus_rd(4'd8, v); check("R7", v == 0, v, 0);
    pulse(1);
    bus_rd(4'd1, v); check("R7", v == 32'hC, v, 32'hC);
    cur_req = "R8";
    idle(10);
    pulse(0);
    bus_rd(4'd7, v); check("R8", v == s0, v, s0);
    cur_req = "R9";
    bus_wr(4'd1, 32'h0);
    bus_rd(4'd1, v); check("R9", v == 32'hC, v, 32'hC);
    bus_wr(4'd1, 32'h4);
    bus_rd(4'd1, v); check("R9", v == 32'h8, v, 32'h8);
    cur_req = "R8";
    pulse(0);
    bus_rd(4'd7, v); check("R8", v != s0, v, s0 + 1);
    bus_wr(4'd1, 32'hFFFF_FFFF);
    bus_rd(4'd1, v); check("R9", v == 0, v, 0);

    cur_req = "R10";
    bus_rd(4'd3, lo);
    bus_rd(4'd4, hi);
    bus_wr(4'd5, lo + 32'd60);
    bus_wr(4'd6, hi);
    bus_rd(4'd1, v); check("R10", v == 0, v, 0);
    idle(120);
    bus_rd(4'd1, v); check("R10", v == 32'h2, v, 32'h2);
    bus_wr(4'd1, 32'h2);
    bus_rd(4'd1, v); check("R10", v == 32'h2, v, 32'h2);
    bus_wr(4'd6, 32'hFFFF_FFFF);
    bus_wr(4'd1, 32'h2);
    idle(20);
    bus_rd(4'd1, v); check("R10", v == 0, v, 0);

    idle(4);
    summary();
    $finish;
  end
endmodule